// File: doc/BRIEF.md
# Triggered Single-Shot Pulse Generator

This block emits one timed pulse for each arming, placed relative to the rising edge of an external trigger. While the block is idle or finished, a host loads three things: an offset, a pulse width and a pair of path enables. Offset and width are both counted in cycles of the generator clock. The host then arms the block. The trigger input first passes through a synchroniser. When its first rising edge is detected, the block counts down the offset and then raises every enabled output path for exactly the width. After that it reports completion and ignores further trigger edges until it is armed again.

The controller is a five-state machine. IDLE is left on `arm` (transition *arm*). ARMED waits for a synchronised trigger edge. That edge leads to WAIT if the offset is nonzero (*trigger-delay*), to FIRE if the offset is zero and the width nonzero (*trigger-fire*), and to DONE if both are zero (*trigger-empty*). WAIT counts down and leaves for FIRE (*delay-expire*), or for DONE when the width is zero (*delay-empty*). FIRE holds for the width and then goes to DONE (*pulse-end*). DONE goes back to ARMED on `arm` (*rearm*). A `disarm` input forces IDLE from any state (*abort*). The offset and the width share one down-counter.

There are two output paths, a low-power one and a high-power one. Each has its own enable, so the host can drive either, both or neither. The output is a plain level for the whole window, with no clock gating inside it.

Top module: `pulse_shot_gen`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `out_lo`, `out_hi` and all four status outputs are 0.
- R2: `arm` in IDLE or DONE moves the block to ARMED on the next edge, where `st_armed` is 1.
- R3: Let E be the first rising clock edge that samples `trig_in` high after a low level while the block is ARMED. The pulse window starts right after edge E+2+offset. With an offset of 0 it starts on the cycle after the synchronised edge is detected.
- R4: A nonzero width W keeps `st_fire` high for exactly W consecutive cycles.
- R5: During the window, `out_lo` equals the loaded low-power enable and `out_hi` equals the loaded high-power enable. Outside the window both are 0.
- R6: After the pulse the block stays in DONE with `st_done` = 1. Later trigger edges produce no pulse until `arm` is given again.
- R7: A width of 0 produces no pulse and no FIRE state, but the block still reaches DONE.
- R8: `load` captures `offset_in`, `width_in`, `en_lo_in` and `en_hi_in` only in IDLE or DONE. In every other state it has no effect on the next pulse.
- R9: `disarm` forces `out_lo` and `out_hi` to 0 in the same cycle, and the block is IDLE (all status 0) after the next edge.
- R10: The status outputs are exclusive: `st_armed` in ARMED, `st_wait` in WAIT, `st_fire` in FIRE, `st_done` in DONE, and all four are 0 in IDLE.
- R11: An offset of 100000 cycles is honoured exactly.
- R12: A trigger edge while IDLE produces no pulse and does not arm the block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm | input | 1 | Arm request, honoured in IDLE and DONE |
| disarm | input | 1 | Abort to IDLE, outputs forced low at once |
| load | input | 1 | Capture offset, width and enables when idle or done |
| offset_in | input | OFF_W | Delay in generator cycles |
| width_in | input | WID_W | Pulse width in generator cycles |
| en_lo_in | input | 1 | Enable for the low-power path |
| en_hi_in | input | 1 | Enable for the high-power path |
| trig_in | input | 1 | Asynchronous external trigger |
| out_lo | output | 1 | Low-power path pulse |
| out_hi | output | 1 | High-power path pulse |
| st_armed | output | 1 | Armed, waiting for trigger |
| st_wait | output | 1 | Counting the offset |
| st_fire | output | 1 | Pulse window active |
| st_done | output | 1 | Shot finished |

## Verification
Some rules hold on every cycle, and assertions check them continuously. These are: the status outputs are exclusive; the abort is honoured on the next edge; WAIT and DONE are held when they must be; arm moves IDLE to ARMED; the detected trigger edge lasts a single cycle; and the captured parameters stay frozen while a shot is in progress. The exact placement of the pulse is shown only by the bench scenarios. This covers the trigger-to-start latency, including the zero offset and a 100000-cycle offset, the exact window length, and which paths toggle. Only the scenarios also show that a shot ends without a pulse, ignores a late load or a repeated trigger, and can be aborted part way through.

// File: rtl/pulse_pkg.sv
`timescale 1ns/1ps
package pulse_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_ARMED = 3'd1,
        ST_WAIT  = 3'd2,
        ST_FIRE  = 3'd3,
        ST_DONE  = 3'd4
    } shot_state_e;
endpackage

// File: rtl/trig_sync.sv
`timescale 1ns/1ps
module trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);
    logic [STAGES-1:0] chain_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= trig_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[g] <= 1'b0;
                    else        chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain_q[STAGES-1];
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

    // R3
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/shot_params.sv
`timescale 1ns/1ps
module shot_params #(
    parameter int OFF_W = 20,
    parameter int WID_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             accept,
    input  logic [OFF_W-1:0] offset_in,
    input  logic [WID_W-1:0] width_in,
    input  logic             en_lo_in,
    input  logic             en_hi_in,
    output logic [OFF_W-1:0] off_q,
    output logic [WID_W-1:0] wid_q,
    output logic             en_lo_q,
    output logic             en_hi_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            off_q   <= '0;
            wid_q   <= '0;
            en_lo_q <= 1'b0;
            en_hi_q <= 1'b0;
        end else if (load && accept) begin
            off_q   <= offset_in;
            wid_q   <= width_in;
            en_lo_q <= en_lo_in;
            en_hi_q <= en_hi_in;
        end
    end

    // R8
    frozen_params_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(off_q) && $stable(wid_q) && $stable(en_lo_q) && $stable(en_hi_q)));
endmodule

// File: rtl/shot_counter.sv
`timescale 1ns/1ps
module shot_counter #(
    parameter int CW = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   cnt_q <= '0;
        else if (load)                cnt_q <= load_val;
        else if (dec && cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign zero = (cnt_q == '0);

    // R4
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);
endmodule

// File: rtl/pulse_shot_gen.sv
`timescale 1ns/1ps
module pulse_shot_gen
    import pulse_pkg::*;
#(
    parameter int OFF_W       = 20,
    parameter int WID_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             disarm,
    input  logic             load,
    input  logic [OFF_W-1:0] offset_in,
    input  logic [WID_W-1:0] width_in,
    input  logic             en_lo_in,
    input  logic             en_hi_in,
    input  logic             trig_in,
    output logic             out_lo,
    output logic             out_hi,
    output logic             st_armed,
    output logic             st_wait,
    output logic             st_fire,
    output logic             st_done
);
    localparam int CW = (OFF_W > WID_W) ? OFF_W : WID_W;

    shot_state_e     state_q, state_d;
    logic            rise;
    logic            accept;
    logic [OFF_W-1:0] off_q;
    logic [WID_W-1:0] wid_q;
    logic            en_lo_q, en_hi_q;
    logic            cnt_load, cnt_dec, cnt_zero;
    logic [CW-1:0]   cnt_val;
    logic [CW-1:0]   off_m1, wid_m1;

    trig_sync #(.STAGES(SYNC_STAGES)) sync_i (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(rise)
    );

    assign accept = (state_q == ST_IDLE) || (state_q == ST_DONE);

    shot_params #(.OFF_W(OFF_W), .WID_W(WID_W)) params_i (
        .clk(clk), .rst_n(rst_n), .load(load), .accept(accept),
        .offset_in(offset_in), .width_in(width_in),
        .en_lo_in(en_lo_in), .en_hi_in(en_hi_in),
        .off_q(off_q), .wid_q(wid_q), .en_lo_q(en_lo_q), .en_hi_q(en_hi_q)
    );

    shot_counter #(.CW(CW)) counter_i (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .zero(cnt_zero)
    );

    assign off_m1 = CW'(off_q) - CW'(1);
    assign wid_m1 = CW'(wid_q) - CW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and counter control
    always_comb begin
        state_d  = state_q;
        cnt_load = 1'b0;
        cnt_dec  = 1'b0;
        cnt_val  = '0;
        unique case (state_q)
            ST_IDLE: begin
                if (arm) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (rise) begin
                    if (off_q != '0) begin
                        state_d  = ST_WAIT;
                        cnt_load = 1'b1;
                        cnt_val  = off_m1;
                    end else if (wid_q != '0) begin
                        state_d  = ST_FIRE;
                        cnt_load = 1'b1;
                        cnt_val  = wid_m1;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end
            end
            ST_WAIT: begin
                if (cnt_zero) begin
                    if (wid_q != '0) begin
                        state_d  = ST_FIRE;
                        cnt_load = 1'b1;
                        cnt_val  = wid_m1;
                    end else begin
                        state_d  = ST_DONE;
                    end
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_FIRE: begin
                if (cnt_zero) state_d = ST_DONE;
                else          cnt_dec = 1'b1;
            end
            ST_DONE: begin
                if (arm) state_d = ST_ARMED;
            end
            default: state_d = ST_IDLE;
        endcase
        if (disarm) begin
            state_d  = ST_IDLE;
            cnt_load = 1'b0;
            cnt_dec  = 1'b0;
        end
    end

    // outputs
    always_comb begin
        st_armed = (state_q == ST_ARMED);
        st_wait  = (state_q == ST_WAIT);
        st_fire  = (state_q == ST_FIRE);
        st_done  = (state_q == ST_DONE);
        out_lo   = st_fire && en_lo_q && !disarm;
        out_hi   = st_fire && en_hi_q && !disarm;
    end

    // R10
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_armed, st_wait, st_fire, st_done}));

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disarm |=> (state_q == ST_IDLE));

    // R2
    arm_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && arm && !disarm) |=> (state_q == ST_ARMED));

    // R6
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DONE && !arm && !disarm) |=> (state_q == ST_DONE));

    // R3
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !cnt_zero && !disarm) |=> (state_q == ST_WAIT));

    // R12
    idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !arm) |=> (state_q == ST_IDLE));
endmodule

// File: tb/pulse_shot_gen_tb.sv
`timescale 1ns/1ps
module pulse_shot_gen_tb_top;
    localparam int OFF_W = 20;
    localparam int WID_W = 16;
    localparam int NVEC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic arm = 1'b0, disarm = 1'b0, load = 1'b0;
    logic [OFF_W-1:0] offset_in = '0;
    logic [WID_W-1:0] width_in = '0;
    logic en_lo_in = 1'b0, en_hi_in = 1'b0, trig_in = 1'b0;
    logic out_lo, out_hi, st_armed, st_wait, st_fire, st_done;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pulse_shot_gen #(.OFF_W(OFF_W), .WID_W(WID_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .arm(arm), .disarm(disarm), .load(load),
        .offset_in(offset_in), .width_in(width_in),
        .en_lo_in(en_lo_in), .en_hi_in(en_hi_in), .trig_in(trig_in),
        .out_lo(out_lo), .out_hi(out_hi), .st_armed(st_armed),
        .st_wait(st_wait), .st_fire(st_fire), .st_done(st_done)
    );

    // {offset, width, en_lo, en_hi}
    localparam logic [37:0] VEC [NVEC] = '{
        {20'd0,   16'd10,  1'b1, 1'b0},
        {20'd1,   16'd1,   1'b1, 1'b1},
        {20'd7,   16'd93,  1'b0, 1'b1},
        {20'd250, 16'd130, 1'b1, 1'b1},
        {20'd3,   16'd5,   1'b0, 1'b0},
        {20'd41,  16'd2,   1'b1, 1'b0}
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    endtask

    task automatic load_and_arm(input int off, input int wid, input bit el, input bit eh);
        @(negedge clk);
        load = 1'b1; arm = 1'b1;
        offset_in = OFF_W'(off); width_in = WID_W'(wid);
        en_lo_in = el; en_hi_in = eh;
        @(negedge clk);
        load = 1'b0; arm = 1'b0;
    endtask

    // raises trig_in, measures window start (edges after E) and length
    task automatic fire_and_measure(input int limit, output int dly, output int len,
                                    output bit lo_bad, output bit hi_bad,
                                    input bit el, input bit eh);
        bit seen;
        seen = 1'b0; dly = -1; len = 0; lo_bad = 1'b0; hi_bad = 1'b0;
        trig_in = 1'b1;
        @(posedge clk);
        for (int j = 0; j < limit && !seen; j++) begin
            @(negedge clk);
            if (st_fire) begin
                seen = 1'b1; dly = j;
            end else begin
                if (out_lo || out_hi) lo_bad = 1'b1;
                @(posedge clk);
            end
        end
        while (seen && st_fire && len < 70000) begin
            if (out_lo != el) lo_bad = 1'b1;
            if (out_hi != eh) hi_bad = 1'b1;
            len++;
            @(posedge clk);
            @(negedge clk);
        end
        trig_in = 1'b0;
    endtask

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #950000;
        n_fail++;
        n_checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int dly, len;
        bit lo_bad, hi_bad;
        bit fired;

        // R1: reset state
        idle_cycles(3);
        check(!out_lo && !out_hi, "R1 outputs in reset", {out_lo, out_hi}, 0);
        check({st_armed, st_wait, st_fire, st_done} == 4'b0, "R1 status in reset",
              {st_armed, st_wait, st_fire, st_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({out_lo, out_hi, st_armed, st_wait, st_fire, st_done} == 6'b0,
              "R1 after reset", {out_lo, out_hi, st_armed, st_wait, st_fire, st_done}, 0);

        // R12: trigger while idle
        fired = 1'b0;
        trig_in = 1'b1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (st_fire || st_armed || out_lo || out_hi) fired = 1'b1;
        end
        trig_in = 1'b0;
        idle_cycles(4);
        check(!fired, "R12 idle trigger ignored", fired, 0);

        // table walk: R2 R3 R4 R5 R6 R10
        for (int v = 0; v < NVEC; v++) begin
            int off, wid;
            bit el, eh;
            off = int'(VEC[v][37:18]);
            wid = int'(VEC[v][17:2]);
            el  = VEC[v][1];
            eh  = VEC[v][0];
            load_and_arm(off, wid, el, eh);
            check(st_armed && !st_wait && !st_fire && !st_done, "R2 armed status",
                  {st_armed, st_wait, st_fire, st_done}, 8);
            fire_and_measure(off + 20, dly, len, lo_bad, hi_bad, el, eh);
            check(dly == off + 2, "R3 trigger to pulse start", dly, off + 2);
            check(len == wid, "R4 pulse width", len, wid);
            check(!lo_bad && !hi_bad, "R5 path enables", {lo_bad, hi_bad}, 0);
            check(st_done && !st_fire && !out_lo && !out_hi, "R10 done status",
                  {st_done, st_fire}, 2);
        end

        // R6: another trigger while DONE
        fired = 1'b0;
        idle_cycles(3);
        trig_in = 1'b1;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (st_fire || st_wait || out_lo || out_hi) fired = 1'b1;
        end
        trig_in = 1'b0;
        idle_cycles(4);
        check(!fired, "R6 single shot no retrigger", fired, 0);
        check(st_done, "R6 stays done", st_done, 1);

        // R7: zero width, offset 3 and offset 0
        load_and_arm(3, 0, 1'b1, 1'b1);
        fire_and_measure(30, dly, len, lo_bad, hi_bad, 1'b1, 1'b1);
        check(dly == -1 && !lo_bad, "R7 zero width no pulse", dly, -1);
        check(st_done, "R7 zero width done", st_done, 1);
        idle_cycles(4);
        load_and_arm(0, 0, 1'b1, 1'b0);
        fire_and_measure(20, dly, len, lo_bad, hi_bad, 1'b1, 1'b0);
        check(dly == -1 && st_done, "R7 zero offset zero width", dly, -1);
        idle_cycles(4);

        // R8: load while armed is ignored
        load_and_arm(5, 7, 1'b1, 1'b0);
        @(negedge clk);
        load = 1'b1; offset_in = 20'd30; width_in = 16'd3; en_lo_in = 1'b0; en_hi_in = 1'b1;
        @(negedge clk);
        load = 1'b0;
        fire_and_measure(60, dly, len, lo_bad, hi_bad, 1'b1, 1'b0);
        check(dly == 7, "R8 offset unchanged while armed", dly, 7);
        check(len == 7, "R8 width unchanged while armed", len, 7);
        check(!lo_bad && !hi_bad, "R8 enables unchanged", {lo_bad, hi_bad}, 0);
        idle_cycles(4);

        // R9: abort during the pulse
        load_and_arm(4, 50, 1'b1, 1'b1);
        trig_in = 1'b1;
        for (int i = 0; i < 30 && !st_fire; i++) @(negedge clk);
        idle_cycles(3);
        check(out_lo && out_hi, "R9 pulse active before abort", {out_lo, out_hi}, 3);
        disarm = 1'b1;
        #1;
        check(!out_lo && !out_hi, "R9 outputs drop at once", {out_lo, out_hi}, 0);
        @(negedge clk);
        disarm = 1'b0;
        check({st_armed, st_wait, st_fire, st_done} == 4'b0, "R9 idle after abort",
              {st_armed, st_wait, st_fire, st_done}, 0);
        trig_in = 1'b0;
        idle_cycles(4);

        // R9: abort while waiting
        load_and_arm(40, 5, 1'b1, 1'b0);
        trig_in = 1'b1;
        idle_cycles(8);
        check(st_wait, "R10 wait status", st_wait, 1);
        disarm = 1'b1;
        @(negedge clk);
        disarm = 1'b0;
        fired = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (st_fire || out_lo) fired = 1'b1;
        end
        trig_in = 1'b0;
        check(!fired && !st_wait, "R9 abort in wait no pulse", fired, 0);
        idle_cycles(4);

        // R11: large offset
        load_and_arm(100000, 10, 1'b0, 1'b1);
        fire_and_measure(100030, dly, len, lo_bad, hi_bad, 1'b0, 1'b1);
        check(dly == 100002, "R11 large offset start", dly, 100002);
        check(len == 10 && !hi_bad, "R11 large offset width", len, 10);

        summary();
        $finish;
    end
endmodule